// File: doc/BRIEF.md
# Dual FIFO Register and Command Front-End

This block sits on a simple synchronous byte register bus and owns two byte FIFOs, one for transmit and one for receive. Each FIFO keeps four pointers: a write pointer, a saved (committed) write pointer, a read pointer and a saved (deallocated) read pointer. Bytes written into a FIFO become readable only once the write side is committed. Space that has been read is released only once the read side is deallocated. Either side can be rolled back: a discard drops uncommitted writes and a retry re-reads undeallocated data. A configuration register chooses, per FIFO, whether commit and deallocate happen automatically on every byte.

One shared data address pushes into the transmit FIFO on a write and pops from the receive FIFO on a read. Each FIFO also has dedicated push and pop addresses. A command register takes byte codes. Codes with the top bit set act on the FIFOs. Lower codes are passed unchanged, one cycle later, to a separate command output for another controller.

Overflow and underflow of either FIFO set sticky bits in an error register. Software clears those bits by writing zero to them. The error interrupt is high while any bit is set. Read data is combinational: it is valid in the same cycle as the read strobe, and the pop takes effect at the end of that cycle.

Top module: `fifo_pair_regfront`

## Requirements
- R1: A write to address 0x0 pushes the write byte into the transmit FIFO. A read of address 0x0 pops the receive FIFO and returns its oldest committed byte in the same cycle.
- R2: The dedicated addresses work as follows. 0x1 pushes the transmit FIFO, 0x2 pops the transmit FIFO, 0x3 pushes the receive FIFO and 0x4 pops the receive FIFO.
- R3: A pushed byte can be read only after a commit. The commit is either automatic, when auto-commit is on for that FIFO, or the command code 0x84 (transmit) or 0x88 (receive).
- R4: A discard, code 0x85 (transmit) or 0x89 (receive), drops every byte written since the last commit.
- R5: A retry, code 0x87 (transmit) or 0x8B (receive), rewinds reading to the last deallocation point, so the same bytes are read again. A deallocate, code 0x86 (transmit) or 0x8A (receive), releases everything read so far, so a later retry returns nothing.
- R6: A FIFO holds DEPTH bytes counted from the deallocation point to the write pointer. A push into a full FIFO is dropped. A pop with no committed unread byte returns 0 and does not move any pointer.
- R7: Code 0x81 empties the transmit FIFO only. Code 0x82 empties the receive FIFO only. Code 0x83 empties both.
- R8: A command write below 0x80 appears on cmdOut with cmdOutValid high for exactly the next cycle. Codes 0x80 to 0xFF are never forwarded.
- R9: Codes 0x80 to 0xFF not listed in R3 to R7 change no FIFO state.
- R10: The error register at address 0x6 has four sticky bits. Bit 0 is receive overflow, bit 1 receive underflow, bit 2 transmit overflow and bit 3 transmit underflow. Writing a 0 to a bit clears it and writing a 1 keeps it. errIrq is high exactly while any bit is set.
- R11: The configuration register at address 0x5 is read and written in bits 3:0. Bit 0 is transmit auto-commit, bit 1 transmit auto-deallocate, bit 2 receive auto-commit and bit 3 receive auto-deallocate. It resets to 0x09.
- R12: When wrEn and rdEn are high in the same cycle, the write is performed. The read returns 0, pops nothing and raises no underflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of rdEn |
| errIrq | output | 1 | Error interrupt, high while any error bit is set |
| cmdOut | output | 8 | Forwarded command byte |
| cmdOutValid | output | 1 | One-cycle pulse marking a forwarded command |

## Verification
If a pointer is wrong inside either FIFO, the fault shows at rdData on the first pop that depends on it. That pop returns a stale byte, a missing byte, or a 0 where data should be. It can also show as an error bit that appears or fails to appear in the next read of the error register. Commit, discard, retry and deallocate are therefore each followed at once by reads that tell a moved pointer from an unmoved one. Filling a FIFO to DEPTH checks the full boundary: the extra push must leave no trace after the stored bytes are drained. A wrong command decode shows one cycle after the command write on cmdOut, or on the next data read.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;

  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int NUM_FIFO = 2;
  localparam int TX_IDX   = 0;
  localparam int RX_IDX   = 1;
  localparam int CFG_W    = 4;

  // register addresses
  localparam logic [ADDR_W-1:0] ADR_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_TXWR = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_TXRD = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_RXWR = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_RXRD = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_CFG  = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_ERR  = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_CMD  = 4'h7;

  // FIFO command codes
  localparam logic [BYTE_W-1:0] CMD_TX_CLR     = 8'h81;
  localparam logic [BYTE_W-1:0] CMD_RX_CLR     = 8'h82;
  localparam logic [BYTE_W-1:0] CMD_BOTH_CLR   = 8'h83;
  localparam logic [BYTE_W-1:0] CMD_TX_COMMIT  = 8'h84;
  localparam logic [BYTE_W-1:0] CMD_TX_DISCARD = 8'h85;
  localparam logic [BYTE_W-1:0] CMD_TX_DEALLOC = 8'h86;
  localparam logic [BYTE_W-1:0] CMD_TX_RETRY   = 8'h87;
  localparam logic [BYTE_W-1:0] CMD_RX_COMMIT  = 8'h88;
  localparam logic [BYTE_W-1:0] CMD_RX_DISCARD = 8'h89;
  localparam logic [BYTE_W-1:0] CMD_RX_DEALLOC = 8'h8A;
  localparam logic [BYTE_W-1:0] CMD_RX_RETRY   = 8'h8B;

  // configuration bits: tx autoCommit, tx autoDealloc, rx autoCommit, rx autoDealloc
  localparam logic [CFG_W-1:0] CFG_RESET = 4'b1001;

  // error bit positions
  localparam int ERR_RX_OVF = 0;
  localparam int ERR_RX_UDF = 1;
  localparam int ERR_TX_OVF = 2;
  localparam int ERR_TX_UDF = 3;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic commit;
    logic discard;
    logic dealloc;
    logic retry;
    logic autoCommit;
    logic autoDealloc;
  } fifoStb_t;

endpackage

// File: rtl/ptr_fifo.sv
module ptr_fifo
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStb_t     stb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] head,
  output logic         overflow,
  output logic         underflow
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, swp, rp, srp;
  logic [PW-1:0] used;
  logic          full, avail, accPush, accPop;

  assign used      = wp - srp;
  assign full      = (used == PW'(DEPTH));
  assign avail     = (swp != rp);
  assign accPush   = stb.push & ~full;
  assign accPop    = stb.pop & avail;
  assign overflow  = stb.push & full;
  assign underflow = stb.pop & ~avail;
  assign head      = avail ? mem[rp[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (accPush) mem[wp[AW-1:0]] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wp  <= '0;
      swp <= '0;
      rp  <= '0;
      srp <= '0;
    end else begin
      if (stb.discard)      wp <= swp;
      else if (accPush)     wp <= wp + 1'b1;

      if (stb.commit)                       swp <= wp;
      else if (accPush && stb.autoCommit)   swp <= wp + 1'b1;

      if (stb.retry)        rp <= srp;
      else if (accPop)      rp <= rp + 1'b1;

      if (stb.dealloc)                      srp <= rp;
      else if (accPop && stb.autoDealloc)   srp <= rp + 1'b1;
    end
  end

endmodule

// File: rtl/fifo_pair_datapath.sv
module fifo_pair_datapath
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  fifoStb_t [NUM_FIFO-1:0]              fifoStb,
  input  logic     [BYTE_W-1:0]                wrData,
  output logic     [NUM_FIFO-1:0][BYTE_W-1:0]  headData,
  output logic     [NUM_FIFO-1:0]              ovfEvt,
  output logic     [NUM_FIFO-1:0]              udfEvt
);

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_fifo
    ptr_fifo #(
      .DEPTH (DEPTH),
      .W     (BYTE_W)
    ) u_fifo (
      .clk       (clk),
      .rstN      (rstN),
      .stb       (fifoStb[i]),
      .wrData    (wrData),
      .head      (headData[i]),
      .overflow  (ovfEvt[i]),
      .underflow (udfEvt[i])
    );
  end

endmodule

// File: rtl/fifo_pair_ctrl.sv
module fifo_pair_ctrl
  import fifo_pair_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic     [ADDR_W-1:0]                addr,
  input  logic                                 wrEn,
  input  logic                                 rdEn,
  input  logic     [BYTE_W-1:0]                wrData,
  output logic     [BYTE_W-1:0]                rdData,
  output logic                                 errIrq,
  output logic     [BYTE_W-1:0]                cmdOut,
  output logic                                 cmdOutValid,
  output fifoStb_t [NUM_FIFO-1:0]              fifoStb,
  input  logic     [NUM_FIFO-1:0][BYTE_W-1:0]  headData,
  input  logic     [NUM_FIFO-1:0]              ovfEvt,
  input  logic     [NUM_FIFO-1:0]              udfEvt
);

  logic [CFG_W-1:0] cfgQ;
  logic [3:0]       errQ, errD;
  logic             rdAcc, isCmdWr, fwdCmd;

  assign rdAcc   = rdEn & ~wrEn;
  assign isCmdWr = wrEn && (addr == ADR_CMD);
  assign fwdCmd  = isCmdWr && !wrData[BYTE_W-1];
  assign errIrq  = |errQ;

  always_comb begin
    fifoStb = '0;
    fifoStb[TX_IDX].autoCommit  = cfgQ[0];
    fifoStb[TX_IDX].autoDealloc = cfgQ[1];
    fifoStb[RX_IDX].autoCommit  = cfgQ[2];
    fifoStb[RX_IDX].autoDealloc = cfgQ[3];
    if (wrEn) begin
      case (addr)
        ADR_DATA, ADR_TXWR: fifoStb[TX_IDX].push = 1'b1;
        ADR_RXWR:           fifoStb[RX_IDX].push = 1'b1;
        ADR_CMD: begin
          case (wrData)
            CMD_TX_CLR:     fifoStb[TX_IDX].clear   = 1'b1;
            CMD_RX_CLR:     fifoStb[RX_IDX].clear   = 1'b1;
            CMD_BOTH_CLR: begin
              fifoStb[TX_IDX].clear = 1'b1;
              fifoStb[RX_IDX].clear = 1'b1;
            end
            CMD_TX_COMMIT:  fifoStb[TX_IDX].commit  = 1'b1;
            CMD_TX_DISCARD: fifoStb[TX_IDX].discard = 1'b1;
            CMD_TX_DEALLOC: fifoStb[TX_IDX].dealloc = 1'b1;
            CMD_TX_RETRY:   fifoStb[TX_IDX].retry   = 1'b1;
            CMD_RX_COMMIT:  fifoStb[RX_IDX].commit  = 1'b1;
            CMD_RX_DISCARD: fifoStb[RX_IDX].discard = 1'b1;
            CMD_RX_DEALLOC: fifoStb[RX_IDX].dealloc = 1'b1;
            CMD_RX_RETRY:   fifoStb[RX_IDX].retry   = 1'b1;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (rdAcc) begin
      case (addr)
        ADR_DATA, ADR_RXRD: fifoStb[RX_IDX].pop = 1'b1;
        ADR_TXRD:           fifoStb[TX_IDX].pop = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAcc) begin
      case (addr)
        ADR_DATA, ADR_RXRD: rdData = headData[RX_IDX];
        ADR_TXRD:           rdData = headData[TX_IDX];
        ADR_CFG:            rdData = {{(BYTE_W-CFG_W){1'b0}}, cfgQ};
        ADR_ERR:            rdData = {{(BYTE_W-4){1'b0}}, errQ};
        default:            rdData = '0;
      endcase
    end
  end

  always_comb begin
    errD = errQ;
    if (wrEn && (addr == ADR_ERR)) errD = errQ & wrData[3:0];
    errD[ERR_RX_OVF] = errD[ERR_RX_OVF] | ovfEvt[RX_IDX];
    errD[ERR_RX_UDF] = errD[ERR_RX_UDF] | udfEvt[RX_IDX];
    errD[ERR_TX_OVF] = errD[ERR_TX_OVF] | ovfEvt[TX_IDX];
    errD[ERR_TX_UDF] = errD[ERR_TX_UDF] | udfEvt[TX_IDX];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ        <= CFG_RESET;
      errQ        <= '0;
      cmdOut      <= '0;
      cmdOutValid <= 1'b0;
    end else begin
      if (wrEn && (addr == ADR_CFG)) cfgQ <= wrData[CFG_W-1:0];
      errQ        <= errD;
      cmdOutValid <= fwdCmd;
      if (fwdCmd) cmdOut <= wrData;
    end
  end

endmodule

// File: rtl/fifo_pair_regfront.sv
module fifo_pair_regfront
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              errIrq,
  output logic [BYTE_W-1:0] cmdOut,
  output logic              cmdOutValid
);

  fifoStb_t [NUM_FIFO-1:0]             fifoStb;
  logic     [NUM_FIFO-1:0][BYTE_W-1:0] headData;
  logic     [NUM_FIFO-1:0]             ovfEvt;
  logic     [NUM_FIFO-1:0]             udfEvt;

  fifo_pair_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .addr        (addr),
    .wrEn        (wrEn),
    .rdEn        (rdEn),
    .wrData      (wrData),
    .rdData      (rdData),
    .errIrq      (errIrq),
    .cmdOut      (cmdOut),
    .cmdOutValid (cmdOutValid),
    .fifoStb     (fifoStb),
    .headData    (headData),
    .ovfEvt      (ovfEvt),
    .udfEvt      (udfEvt)
  );

  fifo_pair_datapath #(
    .DEPTH (DEPTH)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .fifoStb  (fifoStb),
    .wrData   (wrData),
    .headData (headData),
    .ovfEvt   (ovfEvt),
    .udfEvt   (udfEvt)
  );

endmodule

// File: rtl/fifo_pair_regfront_chk.sv
module fifo_pair_regfront_chk
  import fifo_pair_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       addr,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [BYTE_W-1:0]       wrData,
  input logic [BYTE_W-1:0]       rdData,
  input logic                    errIrq,
  input logic [BYTE_W-1:0]       cmdOut,
  input logic                    cmdOutValid,
  input fifoStb_t [NUM_FIFO-1:0] fifoStb
);

  AST_FWD_LOW_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_CMD && !wrData[BYTE_W-1]) |=> (cmdOutValid && cmdOut == $past(wrData))); // R8

  AST_NO_FWD_FIFO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_CMD && wrData[BYTE_W-1]) |=> !cmdOutValid); // R8

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !(wrEn && addr == ADR_ERR)) |=> errIrq); // R10

  AST_ERR_READ_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && addr == ADR_ERR && rdData != '0) |-> errIrq); // R10

  AST_WRITE_BEATS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> (rdData == '0)); // R12

  AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    (fifoStb[TX_IDX].pop || fifoStb[RX_IDX].pop) |-> (rdEn && !wrEn)); // R12

endmodule

bind fifo_pair_regfront fifo_pair_regfront_chk u_chk (.*);

// File: tb/fifo_pair_regfront_test.sv
`timescale 1ns/1ps
module fifo_pair_regfront_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] addr;
  logic       wrEn, rdEn;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       errIrq;
  logic [7:0] cmdOut;
  logic       cmdOutValid;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] mExp;
  string      mTag;

  always #5 clk = ~clk;

  fifo_pair_regfront #(.DEPTH(8)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .errIrq(errIrq),
    .cmdOut(cmdOut), .cmdOutValid(cmdOutValid)
  );

  // monitor: compare read data against the scoreboard mid-cycle
  always @(negedge clk) begin
    if (rstN && rdEn) begin
      vecs++;
      if (expQ.size() == 0) begin
        errs++;
        $display("FAIL scoreboard empty: rdData=%h expected none", rdData);
      end else begin
        mExp = expQ.pop_front();
        mTag = tagQ.pop_front();
        if (rdData !== mExp) begin
          errs++;
          $display("FAIL %s: rdData=%h expected %h", mTag, rdData, mExp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1; rdEn = 1'b0;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag);
    addr = a; rdEn = 1'b1; wrEn = 1'b0;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic rdwr(input logic [3:0] a, input logic [7:0] d, input string tag);
    expQ.push_back(8'h00); tagQ.push_back(tag);
    addr = a; wrData = d; rdEn = 1'b1; wrEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic idle();
    wrEn = 1'b0; rdEn = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string tag);
    vecs++;
    if (act !== e) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, e);
    end
  endtask

  initial begin
    rstN = 1'b0; addr = '0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // reset state
    chk({7'b0, errIrq}, 8'h00, "R10 irq low after reset");
    chk({7'b0, cmdOutValid}, 8'h00, "R8 no command after reset");
    rd(4'h5, 8'h09, "R11 cfg reset value");
    rd(4'h6, 8'h00, "R10 err reset value");

    // shared address to tx, dedicated tx pop
    wr(4'h0, 8'h11);
    wr(4'h0, 8'h22);
    rd(4'h2, 8'h11, "R1 shared write reaches tx");
    rd(4'h2, 8'h22, "R2 tx dedicated pop");
    rd(4'h2, 8'h00, "R6 tx underflow reads zero");
    rd(4'h6, 8'h08, "R10 tx underflow bit3");
    chk({7'b0, errIrq}, 8'h01, "R10 irq on error");
    wr(4'h6, 8'h00);
    rd(4'h6, 8'h00, "R10 write zero clears");
    chk({7'b0, errIrq}, 8'h00, "R10 irq drops when clear");

    // rx: manual commit by default
    wr(4'h3, 8'hA5);
    wr(4'h3, 8'h5A);
    rd(4'h0, 8'h00, "R3 rx not readable before commit");
    wr(4'h7, 8'h88);
    rd(4'h0, 8'hA5, "R1 shared read pops rx");
    rd(4'h4, 8'h5A, "R2 rx dedicated pop");
    wr(4'h7, 8'h8B);
    rd(4'h0, 8'h00, "R5 rx retry after auto-dealloc gives nothing");
    rd(4'h6, 8'h02, "R10 rx underflow bit1");
    wr(4'h6, 8'h02);
    rd(4'h6, 8'h02, "R10 write one keeps bit");
    wr(4'h6, 8'h00);

    // tx manual commit/dealloc: discard, commit, retry, dealloc
    wr(4'h5, 8'h08);
    rd(4'h5, 8'h08, "R11 cfg write");
    wr(4'h7, 8'h81);
    wr(4'h1, 8'h01);
    wr(4'h1, 8'h02);
    wr(4'h7, 8'h85);
    wr(4'h1, 8'h03);
    rd(4'h2, 8'h00, "R3 tx uncommitted not readable");
    wr(4'h7, 8'h84);
    rd(4'h2, 8'h03, "R4 discard dropped earlier bytes");
    rd(4'h2, 8'h00, "R4 nothing after discard");
    wr(4'h7, 8'h87);
    rd(4'h2, 8'h03, "R5 retry re-reads");
    wr(4'h7, 8'h86);
    wr(4'h7, 8'h87);
    rd(4'h2, 8'h00, "R5 dealloc then retry empty");
    wr(4'h6, 8'h00);

    // full / overflow with default config (tx auto-dealloc off)
    wr(4'h5, 8'h09);
    wr(4'h7, 8'h81);
    for (int i = 0; i < 8; i++) wr(4'h0, 8'h30 + 8'(i));
    wr(4'h0, 8'hEE);
    rd(4'h6, 8'h04, "R6 overflow bit2");
    for (int i = 0; i < 8; i++) rd(4'h2, 8'h30 + 8'(i), "R6 stored bytes in order");
    rd(4'h2, 8'h00, "R6 overflow byte not stored");
    wr(4'h0, 8'h77);
    wr(4'h7, 8'h86);
    wr(4'h0, 8'h78);
    rd(4'h2, 8'h78, "R6 space held until dealloc");
    wr(4'h6, 8'h00);
    rd(4'h6, 8'h00, "R10 cleared after overflow");

    // reset commands
    wr(4'h0, 8'h55);
    wr(4'h3, 8'h66);
    wr(4'h7, 8'h88);
    wr(4'h7, 8'h82);
    rd(4'h0, 8'h00, "R7 rx reset empties rx");
    rd(4'h2, 8'h55, "R7 rx reset leaves tx");
    wr(4'h0, 8'h56);
    wr(4'h3, 8'h67);
    wr(4'h7, 8'h88);
    wr(4'h7, 8'h81);
    rd(4'h2, 8'h00, "R7 tx reset empties tx");
    rd(4'h4, 8'h67, "R7 tx reset leaves rx");
    wr(4'h0, 8'h57);
    wr(4'h3, 8'h68);
    wr(4'h7, 8'h88);
    wr(4'h7, 8'h83);
    rd(4'h2, 8'h00, "R7 both reset tx");
    rd(4'h4, 8'h00, "R7 both reset rx");
    wr(4'h6, 8'h00);

    // unassigned FIFO codes
    wr(4'h0, 8'h99);
    wr(4'h7, 8'h80);
    wr(4'h7, 8'hFF);
    wr(4'h7, 8'h8C);
    chk({7'b0, cmdOutValid}, 8'h00, "R8 high code not forwarded");
    rd(4'h2, 8'h99, "R9 unassigned codes ignored");

    // forwarding
    wr(4'h7, 8'h42);
    chk({7'b0, cmdOutValid}, 8'h01, "R8 forward valid");
    chk(cmdOut, 8'h42, "R8 forward value");
    idle();
    chk({7'b0, cmdOutValid}, 8'h00, "R8 valid one cycle");
    wr(4'h7, 8'h7F);
    chk(cmdOut, 8'h7F, "R8 forward top value");

    // simultaneous read and write
    wr(4'h3, 8'h31);
    wr(4'h7, 8'h88);
    rdwr(4'h0, 8'h44, "R12 read ignored on write");
    rd(4'h4, 8'h31, "R12 rx not popped");
    rd(4'h2, 8'h44, "R12 write performed");
    rd(4'h6, 8'h00, "R12 no underflow raised");

    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule